// File: doc/BRIEF.md
# Network Activity LED Controller

This block drives four active-low indicator LEDs from the link and traffic status of an Ethernet port. Its inputs are a link-up flag, a two-bit speed code, and transmit and receive activity strobes. A two-bit mode input picks one of four layouts. Each layout places link indicators, which can be qualified by speed or accept any speed, and activity indicators on the four outputs. An activity indicator can follow transmit only, receive only, or either direction. A combined link/activity indicator can also be selected.

Activity is shown as a timed blink. The indicator first makes a short low phase of about 12 ms and then a long high phase of about 100 ms. After that it is ready for new activity. A free-running prescaler produces a millisecond tick from the system clock frequency parameter. Changing the mode takes effect at the next clock edge and returns every blink timer and the prescaler to rest. All LED outputs are registered.

Top module: `net_led_ctrl`

## Requirements
- R1: While reset is asserted and at the first clock edge after it, all four LED outputs are high (dark).
- R2: An activity indicator at rest is high. When activity is sampled at a clock edge, the indicator output goes low at the following clock edge, which is the second edge counted from the one that sampled the activity.
- R3: The low phase of a blink lasts LOW_MS milliseconds, quantised to the tick. With DIV = CLK_HZ/1000, it spans between (LOW_MS-1)*DIV+1 and LOW_MS*DIV clock cycles.
- R4: The high phase that follows lasts HIGH_MS milliseconds. One idle cycle then tests for activity again. Under continuous activity the output stays high for between (HIGH_MS-1)*DIV+2 and HIGH_MS*DIV+1 cycles before the next low phase.
- R5: Activity that arrives during the low or high phase of a blink is absorbed and neither restarts nor stretches it.
- R6: The transmit indicator follows tx_act_i only. The receive indicator follows rx_act_i only. The combined indicator follows either of them.
- R7: A speed-qualified link indicator is low exactly when link_up_i is high and speed_i matches its rate (0 = 10, 1 = 100, 2 = 1000; code 3 matches none). The any-speed link indicator is low whenever link_up_i is high. Each link indicator updates at the edge after its inputs change.
- R8: The link/activity indicator is steadily high while link_up_i is low, whatever the activity. With link it rests low, and during the low phase of an activity blink (on either direction) it goes high.
- R9: Mode map, given as led_o[0], led_o[1], led_o[2], led_o[3]. Mode 0: transmit, receive, link any speed, link 1000. Mode 1: combined activity, link 10, link 100, link 1000. Mode 2: link/activity, link 10, link 100, link 1000. Mode 3: transmit, receive, combined activity, link/activity.
- R10: A change of mode_i shows the new layout at the next clock edge. At that edge all blink timers and the tick prescaler are back at rest, so every activity indicator is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock at CLK_HZ |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | LED layout select (R9) |
| link_up_i | input | 1 | Link is established |
| speed_i | input | 2 | Link rate: 0 = 10, 1 = 100, 2 = 1000, 3 = none |
| tx_act_i | input | 1 | Transmit activity strobe or level |
| rx_act_i | input | 1 | Receive activity strobe or level |
| led_o | output | 4 | Active-low LED drives |

## Verification
Link and mode results are due one clock edge after the inputs change. A blink first shows on the LEDs two edges after activity is sampled, because the timer register and then the output register lie on the path. The bench changes inputs on the falling edge and samples on the next falling edge after the right number of rising edges. The phase lengths depend on where the prescaler happens to be, so the bench counts the cycles of each low and high run. It then compares each count against the tick-quantised windows of R3 and R4 rather than against a single exact number.

// File: rtl/net_led_pkg.sv
package net_led_pkg;
  typedef enum logic [1:0] {
    LAYOUT_SPLIT_ACT   = 2'd0,
    LAYOUT_SPEED_ACT   = 2'd1,
    LAYOUT_SPEED_LNACT = 2'd2,
    LAYOUT_ALL_ACT     = 2'd3
  } led_layout_e;

  typedef enum logic [1:0] {
    RATE_10   = 2'd0,
    RATE_100  = 2'd1,
    RATE_1000 = 2'd2,
    RATE_NONE = 2'd3
  } link_rate_e;

  // activity source indices for the blink timers
  localparam int SRC_TX   = 0;
  localparam int SRC_RX   = 1;
  localparam int SRC_ANY  = 2;
  localparam int N_SRC    = 3;
endpackage

// File: rtl/led_ms_tick.sv
module led_ms_tick #(
  parameter int DIV = 125000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic tick
);
  localparam int TW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [TW-1:0] cnt;

  assign tick = (cnt == TW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || clr || tick) cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/led_blink_timer.sv
module led_blink_timer #(
  parameter int LOW_MS  = 12,
  parameter int HIGH_MS = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic tick,
  input  logic act,
  output logic blink_lo
);
  localparam int MS_MAX = (LOW_MS > HIGH_MS) ? LOW_MS : HIGH_MS;
  localparam int CW     = $clog2(MS_MAX + 1);

  typedef enum logic [1:0] {ST_REST, ST_LOW, ST_HIGH} blink_st_e;
  blink_st_e     st;
  logic [CW-1:0] ms;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      st <= ST_REST;
      ms <= '0;
    end else begin
      case (st)
        ST_REST: if (act) begin
          st <= ST_LOW;
          ms <= '0;
        end
        ST_LOW: if (tick) begin
          if (ms == CW'(LOW_MS - 1)) begin
            st <= ST_HIGH;
            ms <= '0;
          end else ms <= ms + 1'b1;
        end
        ST_HIGH: if (tick) begin
          if (ms == CW'(HIGH_MS - 1)) begin
            st <= ST_REST;
            ms <= '0;
          end else ms <= ms + 1'b1;
        end
        default: st <= ST_REST;
      endcase
    end
  end

  assign blink_lo = (st == ST_LOW);
endmodule

// File: rtl/net_led_ctrl.sv
module net_led_ctrl
  import net_led_pkg::*;
#(
  parameter int CLK_HZ  = 125000000,
  parameter int LOW_MS  = 12,
  parameter int HIGH_MS = 100
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode_i,
  input  logic       link_up_i,
  input  logic [1:0] speed_i,
  input  logic       tx_act_i,
  input  logic       rx_act_i,
  output logic [3:0] led_o
);
  localparam int TICK_DIV = CLK_HZ / 1000;

  logic [1:0]       mode_q;
  logic             mode_chg;
  logic             tick;
  logic [N_SRC-1:0] act_src;
  logic [N_SRC-1:0] blink_lo;
  logic [N_SRC-1:0] bl;
  logic [3:0]       led_n;

  always_ff @(posedge clk) begin
    if (rst) mode_q <= 2'd0;
    else     mode_q <= mode_i;
  end
  assign mode_chg = (mode_i != mode_q);

  led_ms_tick #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst(rst), .clr(mode_chg), .tick(tick)
  );

  assign act_src[SRC_TX]  = tx_act_i;
  assign act_src[SRC_RX]  = rx_act_i;
  assign act_src[SRC_ANY] = tx_act_i | rx_act_i;

  for (genvar g = 0; g < N_SRC; g++) begin : g_blink
    led_blink_timer #(.LOW_MS(LOW_MS), .HIGH_MS(HIGH_MS)) u_blink (
      .clk(clk), .rst(rst), .clr(mode_chg), .tick(tick),
      .act(act_src[g]), .blink_lo(blink_lo[g])
    );
  end

  always_comb begin
    logic n_any, n_10, n_100, n_1000, n_tx, n_rx, n_act, n_lnact;
    bl      = mode_chg ? '0 : blink_lo;
    n_any   = ~link_up_i;
    n_10    = ~(link_up_i && speed_i == RATE_10);
    n_100   = ~(link_up_i && speed_i == RATE_100);
    n_1000  = ~(link_up_i && speed_i == RATE_1000);
    n_tx    = ~bl[SRC_TX];
    n_rx    = ~bl[SRC_RX];
    n_act   = ~bl[SRC_ANY];
    n_lnact = ~link_up_i | bl[SRC_ANY];
    case (led_layout_e'(mode_i))
      LAYOUT_SPLIT_ACT:   led_n = {n_1000, n_any, n_rx, n_tx};
      LAYOUT_SPEED_ACT:   led_n = {n_1000, n_100, n_10, n_act};
      LAYOUT_SPEED_LNACT: led_n = {n_1000, n_100, n_10, n_lnact};
      default:            led_n = {n_lnact, n_act, n_rx, n_tx};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) led_o <= '1;
    else     led_o <= led_n;
  end
endmodule

// File: rtl/net_led_ctrl_sva.sv
module net_led_ctrl_sva #(
  parameter int TICK_DIV = 4,
  parameter int LOW_MS   = 12
) (
  input logic       clk,
  input logic       rst,
  input logic [1:0] mode_i,
  input logic       link_up_i,
  input logic [1:0] speed_i,
  input logic       tx_act_i,
  input logic       rx_act_i,
  input logic [2:0] blink_lo,
  input logic [3:0] led_o
);
  logic       past_ok;
  logic [1:0] mode_d;
  int         low_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      past_ok <= 1'b0;
      mode_d  <= 2'd0;
      low_run <= 0;
    end else begin
      past_ok <= 1'b1;
      mode_d  <= mode_i;
      low_run <= blink_lo[0] ? low_run + 1 : 0;
    end
  end

  // R1
  a_r1_reset_dark: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> led_o == 4'hF);
  // R2, R6: a transmit blink starts only on transmit activity
  a_r2_tx_start: assert property (@(posedge clk) disable iff (rst)
    $rose(blink_lo[0]) |-> $past(tx_act_i));
  // R6: a receive blink starts only on receive activity
  a_r6_rx_start: assert property (@(posedge clk) disable iff (rst)
    $rose(blink_lo[1]) |-> $past(rx_act_i));
  // R3, R5: the low phase never runs past its window
  a_r3_low_bounded: assert property (@(posedge clk) disable iff (rst)
    low_run <= LOW_MS * TICK_DIV);
  // R7
  a_r7_link10: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(mode_i) == 2'd2 |->
      led_o[1] == !($past(link_up_i) && $past(speed_i) == 2'd0));
  // R8
  a_r8_no_link_high: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(mode_i) == 2'd3 && !$past(link_up_i) |-> led_o[3]);
  // R10
  a_r10_mode_clears: assert property (@(posedge clk) disable iff (rst)
    past_ok && mode_i != mode_d |=> blink_lo == 3'b000);
endmodule

bind net_led_ctrl net_led_ctrl_sva #(.TICK_DIV(TICK_DIV), .LOW_MS(LOW_MS)) u_sva (
  .clk(clk), .rst(rst), .mode_i(mode_i), .link_up_i(link_up_i),
  .speed_i(speed_i), .tx_act_i(tx_act_i), .rx_act_i(rx_act_i),
  .blink_lo(blink_lo), .led_o(led_o)
);

// File: tb/net_led_ctrl_tb.sv
module net_led_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ  = 4000;
  localparam int DIV     = CLK_HZ / 1000;
  localparam int LOW_MS  = 12;
  localparam int HIGH_MS = 100;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode_i = 2'd0;
  logic       link_up_i = 1'b0;
  logic [1:0] speed_i = 2'd0;
  logic       tx_act_i = 1'b0;
  logic       rx_act_i = 1'b0;
  logic [3:0] led_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  net_led_ctrl #(.CLK_HZ(CLK_HZ), .LOW_MS(LOW_MS), .HIGH_MS(HIGH_MS)) u_dut (
    .clk(clk), .rst(rst), .mode_i(mode_i), .link_up_i(link_up_i),
    .speed_i(speed_i), .tx_act_i(tx_act_i), .rx_act_i(rx_act_i), .led_o(led_o)
  );

  // expected LEDs with every blink at rest (R7, R8, R9)
  function automatic logic [3:0] exp_rest(input logic [1:0] m, input logic lk,
                                          input logic [1:0] sp);
    logic a, s10, s100, s1000, la;
    a     = ~lk;
    s10   = ~(lk && sp == 2'd0);
    s100  = ~(lk && sp == 2'd1);
    s1000 = ~(lk && sp == 2'd2);
    la    = ~lk;
    case (m)
      2'd0:    return {s1000, a, 1'b1, 1'b1};
      2'd1:    return {s1000, s100, s10, 1'b1};
      2'd2:    return {s1000, s100, s10, la};
      default: return {la, 1'b1, 1'b1, 1'b1};
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp, input bit ok);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_range(input string req, input int v, input int lo, input int hi);
    check(req, v, lo, (v >= lo) && (v <= hi));
  endtask

  initial begin
    int n;
    bit ok;
    logic [1:0] m, sp;
    logic lk;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 during reset", led_o, 4'hF, led_o == 4'hF);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset", led_o, 4'hF, led_o == 4'hF);

    // directed: mode 0, 1000 link
    mode_i = 2'd0; link_up_i = 1'b1; speed_i = 2'd2;
    @(negedge clk);
    check("R9 mode0 link1000", led_o, 4'b0011, led_o == 4'b0011);
    speed_i = 2'd3;
    @(negedge clk);
    check("R7 speed code none", led_o, 4'b1011, led_o == 4'b1011);

    // random static layouts, no activity (R7, R9)
    for (int i = 0; i < 40; i++) begin
      m  = 2'($urandom_range(0, 3));
      lk = 1'($urandom_range(0, 1));
      sp = 2'($urandom_range(0, 3));
      mode_i = m; link_up_i = lk; speed_i = sp;
      @(negedge clk);
      check("R7 R9 random layout", led_o, exp_rest(m, lk, sp),
            led_o == exp_rest(m, lk, sp));
    end

    // mode 3, link 1000, transmit held: R2..R6, R8
    mode_i = 2'd3; link_up_i = 1'b1; speed_i = 2'd2;
    repeat (3) @(negedge clk);
    check("R8 link rests low", led_o, 4'b0111, led_o == 4'b0111);
    tx_act_i = 1'b1;
    @(negedge clk);
    check("R2 no change one edge after", led_o, 4'b0111, led_o == 4'b0111);
    @(negedge clk);
    check("R2 R6 R8 blink low phase", led_o, 4'b1010, led_o == 4'b1010);
    n = 1; ok = 1'b1;
    for (int k = 0; k < 1000; k++) begin
      @(negedge clk);
      if (led_o[0]) break;
      if (led_o != 4'b1010) ok = 1'b0;
      n++;
    end
    check("R6 R8 pattern in low phase", ok, 1, ok);
    check_range("R3 R5 low length", n, (LOW_MS-1)*DIV+1, LOW_MS*DIV);
    n = 1; ok = (led_o == 4'b0111);
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      if (!led_o[0]) break;
      if (led_o != 4'b0111) ok = 1'b0;
      n++;
    end
    check("R6 R8 pattern in high phase", ok, 1, ok);
    check_range("R4 R5 high length", n, (HIGH_MS-1)*DIV+2, HIGH_MS*DIV+1);
    check("R4 restart low", led_o, 4'b1010, led_o == 4'b1010);

    // R10: mode change in the middle of a blink
    repeat (5) @(negedge clk);
    tx_act_i = 1'b0;
    mode_i = 2'd1;
    @(negedge clk);
    check("R10 new layout at rest", led_o, 4'b0111, led_o == 4'b0111);
    repeat (20) @(negedge clk);
    check("R10 timers stay at rest", led_o, 4'b0111, led_o == 4'b0111);

    // R6: receive only, mode 0, link 10
    mode_i = 2'd0; speed_i = 2'd0;
    repeat (2) @(negedge clk);
    check("R9 mode0 link10", led_o, 4'b1011, led_o == 4'b1011);
    rx_act_i = 1'b1;
    @(negedge clk);
    rx_act_i = 1'b0;
    @(negedge clk);
    check("R2 R6 rx blink only", led_o, 4'b1001, led_o == 4'b1001);
    n = 1;
    for (int k = 0; k < 1000; k++) begin
      @(negedge clk);
      if (led_o[1]) break;
      n++;
    end
    check_range("R3 rx low length", n, (LOW_MS-1)*DIV+1, LOW_MS*DIV);
    repeat (HIGH_MS*DIV + 4) @(negedge clk);
    check("R2 back at rest", led_o, 4'b1011, led_o == 4'b1011);

    // R8: no link, activity present, mode 2
    mode_i = 2'd2; link_up_i = 1'b0; tx_act_i = 1'b1; rx_act_i = 1'b1;
    ok = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 500; k++) begin
      @(negedge clk);
      if (!led_o[0]) ok = 1'b0;
    end
    check("R8 no link stays high", ok, 1, ok);
    // link returns: blink already running shows as inverted activity
    link_up_i = 1'b1; speed_i = 2'd1;
    tx_act_i = 1'b0; rx_act_i = 1'b0;
    @(negedge clk);
    check("R7 link100 in mode2", led_o[3:1], 3'b101, led_o[3:1] == 3'b101);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule